// File: doc/BRIEF.md
# Maintenance Request Dispatcher

This block sits behind a memory device's command mailbox and handles the "perform maintenance" command (command set 0x06, command 0x00, full opcode 0x0600). It takes one 14-byte request payload through a valid/ready handshake and unpacks it. It then picks a 2-bit completion code. When the request asks for a post-package row repair, it sends a one-cycle repair strobe, with the target address, to a separate tracker of pending repairs. The mailbox transport, event records and the repair itself are handled elsewhere.

The payload is a flat 112-bit vector whose byte k sits at bits [8k+7:8k]. The byte fields are:

| Bytes | Field |
|---|---|
| 0 | operation class |
| 1 | subclass |
| 2 | flag byte |
| 3 to 10 | 64-bit device address, least significant byte first |
| 11 to 13 | 24-bit nibble mask |

A background-operation engine reports whether an operation is running and which opcode it is. A running maintenance operation (opcode 0x0600) makes every new request complete as busy.

The controller is a two-state machine:

- **IDLE**: ready is high. On accept (valid and ready at a rising edge) the machine takes the transition IDLE→REPLY and registers the decoded outcome.
- **REPLY**: done, the completion code and, when due, the repair strobe are presented for exactly one cycle. The machine then takes the unconditional transition REPLY→IDLE.

Top module: `maint_dispatch`

## Requirements
- R1: After reset, req_ready is 1 and done and repair_stb are 0.
- R2: If bg_running is 1 and bg_opcode is 0x0600 in the accept cycle, the completion is BUSY (code 1) whatever the payload holds, and no strobe is issued.
- R3: A running background operation with any opcode other than 0x0600 does not block the request; it decodes normally.
- R4: Class 0 completes with SUCCESS (code 0) and no strobe.
- R5: Class 1 with bit 0 of the flag byte (query resources) set completes with SUCCESS and no strobe, whatever the subclass.
- R6: Class 1 with query clear and subclass 0 (soft) or 1 (hard) completes with SUCCESS. In the done cycle it raises repair_stb. repair_addr carries bytes 3 to 10 read as a little-endian value, repair_mask carries bytes 11 to 13 (byte 11 least significant), and repair_hard is 1 only for subclass 1.
- R7: Class 1 with query clear and any subclass above 1 completes with INVALID_INPUT (code 3).
- R8: Classes 2 and 3 complete with UNSUPPORTED (code 2).
- R9: Any class value of 4 or above completes with INVALID_INPUT.
- R10: done rises in the cycle after accept, lasts exactly one cycle, and req_ready is 0 while done is 1.
- R11: repair_stb is only ever 1 together with done and a SUCCESS code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | rising-edge clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | dispatcher can take a request |
| req_payload | input | 112 | request bytes, byte k at bits [8k+7:8k] |
| bg_running | input | 1 | a background operation is in progress |
| bg_opcode | input | 16 | opcode of that background operation |
| done | output | 1 | one-cycle completion pulse |
| status | output | 2 | completion code: 0 SUCCESS, 1 BUSY, 2 UNSUPPORTED, 3 INVALID_INPUT |
| repair_stb | output | 1 | one-cycle repair request to the tracker |
| repair_addr | output | 64 | device address to repair |
| repair_mask | output | 24 | nibble mask to repair |
| repair_hard | output | 1 | 1 for a hard repair, 0 for a soft repair |

## Verification
The assertions assume that bg_running and bg_opcode are stable and meaningful in the accept cycle. They also assume that req_payload is only sampled when valid and ready are both high. They make no claim about outputs outside the done cycle, apart from repair_stb staying low. The stimulus drives all inputs on the falling edge and holds them through the accept edge. It drops valid in the done cycle, so no back-to-back accept can overlap a reply. Random payloads weight class values toward 0 to 5 and subclasses toward 0 to 3, so that every decode branch is reached. Directed cases cover a busy engine with a valid repair request, a foreign background opcode, class 255 and the query flag combined with a hard-repair subclass.

// File: rtl/maint_pkg.sv
package maint_pkg;

    // completion codes, values fixed by the brief
    typedef enum logic [1:0] {
        CMP_SUCCESS     = 2'd0,
        CMP_BUSY        = 2'd1,
        CMP_UNSUPPORTED = 2'd2,
        CMP_INVALID     = 2'd3
    } cmp_code_e;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_REPLY = 1'b1
    } disp_state_e;

    localparam logic [15:0] MAINT_OPCODE  = 16'h0600;
    localparam logic [7:0]  CLS_NOP       = 8'd0;
    localparam logic [7:0]  CLS_REPAIR    = 8'd1;
    localparam logic [7:0]  CLS_UNSUP_LO  = 8'd2;
    localparam logic [7:0]  CLS_UNSUP_HI  = 8'd3;
    localparam logic [7:0]  SUB_SOFT      = 8'd0;
    localparam logic [7:0]  SUB_HARD      = 8'd1;
    localparam int          QUERY_BIT     = 0;

endpackage

// File: rtl/maint_unpack.sv
module maint_unpack #(
    parameter int ADDR_BYTES = 8,
    parameter int MASK_BYTES = 3,
    localparam int HDR_BYTES = 3,
    localparam int PAY_BYTES = HDR_BYTES + ADDR_BYTES + MASK_BYTES,
    localparam int PAY_W     = PAY_BYTES * 8,
    localparam int ADDR_W    = ADDR_BYTES * 8,
    localparam int MASK_W    = MASK_BYTES * 8
) (
    input  logic [PAY_W-1:0]  payload,
    output logic [7:0]        cls,
    output logic [7:0]        sub,
    output logic [7:0]        flags,
    output logic [ADDR_W-1:0] addr,
    output logic [MASK_W-1:0] mask
);

    assign cls   = payload[7:0];
    assign sub   = payload[15:8];
    assign flags = payload[23:16];

    // little-endian: lowest payload byte lands in the lowest address byte
    for (genvar a = 0; a < ADDR_BYTES; a++) begin : g_addr
        assign addr[a*8 +: 8] = payload[(HDR_BYTES + a)*8 +: 8];
    end

    for (genvar m = 0; m < MASK_BYTES; m++) begin : g_mask
        assign mask[m*8 +: 8] = payload[(HDR_BYTES + ADDR_BYTES + m)*8 +: 8];
    end

endmodule

// File: rtl/maint_decode.sv
module maint_decode
    import maint_pkg::*;
(
    input  logic [7:0] cls,
    input  logic [7:0] sub,
    input  logic       query,
    input  logic       blocked,
    output cmp_code_e  code,
    output logic       do_repair,
    output logic       hard
);

    always_comb begin
        code      = CMP_INVALID;
        do_repair = 1'b0;
        hard      = (sub == SUB_HARD);
        if (blocked) begin
            code = CMP_BUSY;
        end else if (cls == CLS_NOP) begin
            code = CMP_SUCCESS;
        end else if (cls == CLS_REPAIR) begin
            if (query) begin
                code = CMP_SUCCESS;
            end else if (sub == SUB_SOFT || sub == SUB_HARD) begin
                code      = CMP_SUCCESS;
                do_repair = 1'b1;
            end else begin
                code = CMP_INVALID;
            end
        end else if (cls == CLS_UNSUP_LO || cls == CLS_UNSUP_HI) begin
            code = CMP_UNSUPPORTED;
        end else begin
            code = CMP_INVALID;
        end
    end

endmodule

// File: rtl/maint_dispatch.sv
module maint_dispatch
    import maint_pkg::*;
#(
    parameter int ADDR_BYTES = 8,
    parameter int MASK_BYTES = 3,
    parameter int OPC_W      = 16,
    localparam int PAY_W     = (3 + ADDR_BYTES + MASK_BYTES) * 8,
    localparam int ADDR_W    = ADDR_BYTES * 8,
    localparam int MASK_W    = MASK_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PAY_W-1:0]  req_payload,
    input  logic              bg_running,
    input  logic [OPC_W-1:0]  bg_opcode,
    output logic              done,
    output logic [1:0]        status,
    output logic              repair_stb,
    output logic [ADDR_W-1:0] repair_addr,
    output logic [MASK_W-1:0] repair_mask,
    output logic              repair_hard
);

    disp_state_e state_q, state_d;
    cmp_code_e   code_q, dec_code;
    logic        rep_q, hard_q, dec_rep, dec_hard, accept, blocked;
    logic [7:0]  f_cls, f_sub, f_flags;
    logic [ADDR_W-1:0] f_addr, addr_q;
    logic [MASK_W-1:0] f_mask, mask_q;

    maint_unpack #(.ADDR_BYTES(ADDR_BYTES), .MASK_BYTES(MASK_BYTES)) u_unpack (
        .payload (req_payload),
        .cls     (f_cls),
        .sub     (f_sub),
        .flags   (f_flags),
        .addr    (f_addr),
        .mask    (f_mask)
    );

    assign blocked = bg_running && (bg_opcode == OPC_W'(MAINT_OPCODE));

    maint_decode u_decode (
        .cls       (f_cls),
        .sub       (f_sub),
        .query     (f_flags[QUERY_BIT]),
        .blocked   (blocked),
        .code      (dec_code),
        .do_repair (dec_rep),
        .hard      (dec_hard)
    );

    assign accept = req_valid && (state_q == S_IDLE);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = S_REPLY;
            S_REPLY: state_d = S_IDLE;
        endcase
    end

    // state and captured outcome
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            code_q  <= CMP_SUCCESS;
            rep_q   <= 1'b0;
            hard_q  <= 1'b0;
            addr_q  <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                code_q <= dec_code;
                rep_q  <= dec_rep;
                hard_q <= dec_hard;
                addr_q <= f_addr;
                mask_q <= f_mask;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        done        = 1'b0;
        repair_stb  = 1'b0;
        status      = code_q;
        repair_addr = addr_q;
        repair_mask = mask_q;
        repair_hard = hard_q;
        unique case (state_q)
            S_IDLE:  req_ready = 1'b1;
            S_REPLY: begin
                done       = 1'b1;
                repair_stb = rep_q;
            end
        endcase
    end

    // R10
    done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> done);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    ready_low_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);
    // R11
    strobe_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repair_stb |-> (done && status == 2'd0));
    // R2
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && bg_running && bg_opcode == OPC_W'(16'h0600))
        |=> (status == 2'd1 && !repair_stb));
    // R8
    unsup_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !bg_running &&
         (req_payload[7:0] == 8'd2 || req_payload[7:0] == 8'd3))
        |=> (status == 2'd2));

endmodule

// File: tb/test_maint_dispatch.sv
module test_maint_dispatch;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [111:0]  req_payload = '0;
    logic          bg_running = 1'b0;
    logic [15:0]   bg_opcode = '0;
    logic          done;
    logic [1:0]    status;
    logic          repair_stb;
    logic [63:0]   repair_addr;
    logic [23:0]   repair_mask;
    logic          repair_hard;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    maint_dispatch i_maint_dispatch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_payload(req_payload), .bg_running(bg_running), .bg_opcode(bg_opcode),
        .done(done), .status(status), .repair_stb(repair_stb),
        .repair_addr(repair_addr), .repair_mask(repair_mask), .repair_hard(repair_hard)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input logic [7:0] c, input logic [7:0] s,
                                           input logic [7:0] f, input bit busy);
        if (busy) return 2'd1;
        if (c == 0) return 2'd0;
        if (c == 1) begin
            if (f[0]) return 2'd0;
            if (s <= 1) return 2'd0;
            return 2'd3;
        end
        if (c == 2 || c == 3) return 2'd2;
        return 2'd3;
    endfunction

    function automatic bit exp_rep(input logic [7:0] c, input logic [7:0] s,
                                   input logic [7:0] f, input bit busy);
        return !busy && c == 1 && !f[0] && s <= 1;
    endfunction

    task automatic send(input logic [7:0] c, input logic [7:0] s, input logic [7:0] f,
                        input logic [63:0] a, input logic [23:0] m,
                        input bit bgr, input logic [15:0] bgo, input string req);
        bit busy;
        bit er;
        logic [1:0] ec;
        busy = bgr && bgo == 16'h0600;
        ec = exp_code(c, s, f, busy);
        er = exp_rep(c, s, f, busy);
        @(negedge clk);
        req_payload = {m, a[63:56], a[55:48], a[47:40], a[39:32],
                       a[31:24], a[23:16], a[15:8], a[7:0], f, s, c};
        bg_running = bgr;
        bg_opcode  = bgo;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        bg_running = 1'b0;
        chk(done == 1'b1, {"R10 done ", req}, 64'(done), 64'd1);
        chk(req_ready == 1'b0, {"R10 ready ", req}, 64'(req_ready), 64'd0);
        chk(status == ec, {req, " status"}, 64'(status), 64'(ec));
        chk(repair_stb == er, {req, " strobe R11"}, 64'(repair_stb), 64'(er));
        if (er) begin
            chk(repair_addr == a, "R6 addr", repair_addr, a);
            chk(repair_mask == m, "R6 mask", 64'(repair_mask), 64'(m));
            chk(repair_hard == s[0], "R6 hard", 64'(repair_hard), 64'(s[0]));
        end
        @(negedge clk);
        chk(done == 1'b0 && repair_stb == 1'b0 && req_ready == 1'b1,
            {"R10 back to idle ", req}, 64'({done, repair_stb, req_ready}), 64'b001);
    endtask

    function automatic string tag_for(input logic [7:0] c, input logic [7:0] s,
                                      input logic [7:0] f, input bit busy);
        if (busy) return "R2";
        if (c == 0) return "R4";
        if (c == 1 && f[0]) return "R5";
        if (c == 1 && s <= 1) return "R6";
        if (c == 1) return "R7";
        if (c == 2 || c == 3) return "R8";
        return "R9";
    endfunction

    initial begin
        #(20 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1 && done == 1'b0 && repair_stb == 1'b0, "R1 reset",
            64'({req_ready, done, repair_stb}), 64'b100);
        rst_n = 1'b1;
        @(negedge clk);

        send(8'd1, 8'd0, 8'd0, 64'h0123_4567_89ab_cdef, 24'habcdef, 1'b1, 16'h0600, "R2 busy repair");
        send(8'd1, 8'd1, 8'd0, 64'hfedc_ba98_7654_3210, 24'h123456, 1'b1, 16'h4304, "R3 foreign bg");
        send(8'd0, 8'd9, 8'hff, 64'h1, 24'h0, 1'b0, 16'h0, "R4 nop");
        send(8'd1, 8'd1, 8'h01, 64'h55, 24'h7, 1'b0, 16'h0, "R5 query");
        send(8'd1, 8'd0, 8'hfe, 64'h8000_0000_0000_0001, 24'h800001, 1'b0, 16'h0, "R6 soft");
        send(8'd1, 8'd1, 8'h00, 64'hdead_beef_cafe_f00d, 24'hffffff, 1'b0, 16'h0, "R6 hard");
        send(8'd1, 8'd2, 8'h00, 64'h2, 24'h2, 1'b0, 16'h0, "R7 bad subclass");
        send(8'd2, 8'd0, 8'h00, 64'h3, 24'h3, 1'b0, 16'h0, "R8 class2");
        send(8'd3, 8'd1, 8'h00, 64'h4, 24'h4, 1'b0, 16'h0, "R8 class3");
        send(8'd4, 8'd0, 8'h00, 64'h5, 24'h5, 1'b0, 16'h0, "R9 class4");
        send(8'd255, 8'd0, 8'h00, 64'h6, 24'h6, 1'b0, 16'h0, "R9 class255");

        for (int i = 0; i < 400; i++) begin
            logic [7:0]  c, s, f;
            logic [63:0] a;
            logic [15:0] o;
            bit          r;
            c = ($urandom % 4 != 0) ? 8'($urandom % 6) : 8'($urandom);
            s = ($urandom % 4 != 0) ? 8'($urandom % 4) : 8'($urandom);
            f = 8'($urandom);
            a = {$urandom, $urandom};
            r = ($urandom % 3 == 0);
            o = ($urandom % 2 == 0) ? 16'h0600 : 16'($urandom);
            send(c, s, f, a, 24'($urandom), r, o, tag_for(c, s, f, r && o == 16'h0600));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule